// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets a host configure a bank of 10-bit control registers over three wires: a serial clock, a data line and an active-low load strobe. The host lowers the strobe and shifts 16-bit command words in MSB first. Each word is either a write, which stores its payload in the addressed register, or a read request, which makes the block send the addressed register back on a serial output. A polarity pin selects which serial clock edge samples the input. The reply is launched on the opposite edge.

The port runs on a fast system clock. It finds the serial clock edges by comparing the pin with its registered copy, so every register in the block shares one clock domain. All register contents are presented in parallel on one flat output bus for the rest of the chip. Register `k` sits at bits `[10k+9 : 10k]`. An asynchronous active-low reset and a self-reset bit in the control register both restore every register to its default value.

Top module: `serial_reg_port`

The receiver state machine has two states. `RX_IDLE` is entered and held while the strobe is high. `RX_SHIFT` is entered on the first cycle with the strobe low and counts sample edges. The reply state machine also has two states. `TX_IDLE` holds the output low. `TX_SEND` shifts a 16-bit reply. It moves from idle to send on a launch edge while a reply is armed. It moves back to idle on a launch edge after the last reply bit if nothing else is armed.

## Requirements
- R1: A command word is 16 bits, shifted MSB first. Bit 15 selects the access: 0 writes, 1 reads. Bits 14:10 hold the address and bits 9:0 the payload. A write updates the register bus at the 16th sample edge of the word.
- R2: Sample edges count only while the load strobe is low. Several words may follow one another in one low period. Raising the strobe discards any incomplete word, and that word has no effect.
- R3: With the polarity pin at 1, input is sampled on rising serial clock edges and the output changes on falling edges. With the pin at 0, input is sampled on falling edges and the output changes on rising edges.
- R4: The implemented register bits are: address 0 bits 9:7; address 1 bits 9:0; addresses 2 and 3 bits 8:0; address 6 bits 7:0; address 7 bits 9:0; address 8 bits 4:0; address 9 bits 4:0; address 10 bits 7:0. All other bits of these registers are not stored and read as 0.
- R5: A read request makes the block send a 16-bit reply, MSB first. The top 6 bits are 0 and the low 10 bits hold the register value at the request's last edge. When the strobe stays low, the host samples the reply MSB at the 2nd sample edge after the request ends and the LSB 15 edges later. Back-to-back requests give back-to-back replies.
- R6: While the strobe is high, the reply neither starts nor advances and the output holds its level. A reply still pending when the strobe is raised starts at the launch edge after the first sample edge with the strobe low again.
- R7: Writes to addresses 4, 5 and 11 to 31 change no register. Reads from these addresses return 0.
- R8: A write to address 0 with payload bit 0 at 1 restores every register to its default. Bit 0 itself is never stored. Driving the reset input low does the same.
- R9: Defaults: address 0 holds 0x380, address 6 holds 64, address 9 holds 0x010, and every other register holds 0.
- R10: The serial output is 0 whenever no reply is being sent. It changes only right after a launch edge.
- R11: Clearing the standby bit (address 0, bit 9) does not block later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_n_i | input | 1 | Asynchronous active-low reset, restores defaults |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low word framing strobe |
| pol_i | input | 1 | Sampling edge select: 1 rising, 0 falling |
| sdo_o | output | 1 | Serial reply data |
| regs_o | output | 110 | Flat image of all 11 registers, register k at bits 10k+9:10k |

## Verification
The bench builds the block with the package defaults: 16-bit words, 5-bit addresses, 10-bit payloads and 11 registers. These values let it reach every implemented register as well as the reserved and unimplemented addresses up to 31. Stimulus streams of up to 64 bits hold three whole words in one strobe period. This makes two chained replies and a trailing partial word reachable, along with the paused reply across a strobe release. Both polarity settings are mixed into the random sequence.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int WORD_W       = 16;
    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 10;
    localparam int NUM_REGS     = 11;
    localparam int CNT_W        = $clog2(WORD_W);
    localparam int LEFT_W       = CNT_W + 1;
    localparam int FLAT_W       = NUM_REGS * DATA_W;
    localparam int PAD_W        = WORD_W - DATA_W;
    localparam int RW_BIT       = WORD_W - 1;
    localparam int SELF_RST_BIT = 0;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    // implemented bits per register; zero mask marks an unused address
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       reg_mask = DATA_W'(10'h380);
            1:       reg_mask = DATA_W'(10'h3FF);
            2, 3:    reg_mask = DATA_W'(10'h1FF);
            6:       reg_mask = DATA_W'(10'h0FF);
            7:       reg_mask = DATA_W'(10'h3FF);
            8, 9:    reg_mask = DATA_W'(10'h01F);
            10:      reg_mask = DATA_W'(10'h0FF);
            default: reg_mask = '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       reg_default = DATA_W'(10'h380);
            6:       reg_default = DATA_W'(10'h040);
            9:       reg_default = DATA_W'(10'h010);
            default: reg_default = '0;
        endcase
    endfunction

    function automatic logic [FLAT_W-1:0] default_image();
        logic [FLAT_W-1:0] img;
        img = '0;
        for (int i = 0; i < NUM_REGS; i++) img[i*DATA_W +: DATA_W] = reg_default(i);
        return img;
    endfunction
endpackage

// File: rtl/srp_rx.sv
module srp_rx
    import srp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              smp_i,
    input  logic              load_n_i,
    input  logic              sdi_i,
    output logic              wr_o,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    typedef enum logic {RX_IDLE, RX_SHIFT} rx_state_t;

    rx_state_t         state_q, state_d;
    logic [WORD_W-2:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] word;
    logic              take, last;

    assign word = {shift_q, sdi_i};
    assign take = smp_i && (state_q == RX_SHIFT) && !load_n_i;
    assign last = take && (cnt_q == CNT_W'(WORD_W - 1));

    always_comb begin
        unique case (state_q)
            RX_IDLE:  state_d = load_n_i ? RX_IDLE : RX_SHIFT;
            RX_SHIFT: state_d = load_n_i ? RX_IDLE : RX_SHIFT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= RX_IDLE;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (load_n_i) begin
            cnt_q   <= '0;
        end else if (take) begin
            shift_q <= word[WORD_W-2:0];
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        wr_o   = last && !word[RW_BIT];
        rd_o   = last &&  word[RW_BIT];
        addr_o = word[RW_BIT-1 -: ADDR_W];
        data_o = word[DATA_W-1:0];
    end

    AST_FRAME_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_n_i |=> (cnt_q == '0 && !wr_o && !rd_o)); // R2
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [FLAT_W-1:0] regs_o
);
    logic soft_rst;

    assign soft_rst = wr_i && (addr_i == CTRL_ADDR) && data_i[SELF_RST_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = reg_mask(g);
        localparam logic [DATA_W-1:0] DEF  = reg_default(g);
        logic [DATA_W-1:0] val_q;

        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i)                                val_q <= DEF;
            else if (soft_rst)                           val_q <= DEF;
            else if (wr_i && addr_i == ADDR_W'(g))       val_q <= data_i & MASK;
        end

        assign regs_o[g*DATA_W +: DATA_W] = val_q;
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr_i == ADDR_W'(i)) rd_data_o = regs_o[i*DATA_W +: DATA_W];
    end

    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_i && reg_mask(int'(addr_i)) == '0) |=> $stable(regs_o)); // R7
    AST_SELF_RESET_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_i && addr_i == '0 && data_i[0]) |=> (regs_o == default_image())); // R8
endmodule

// File: rtl/srp_tx.sv
module srp_tx
    import srp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              smp_i,
    input  logic              lau_i,
    input  logic              load_n_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sdo_o
);
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] out_q, pend_q;
    logic              pend_v_q, armed_q;
    logic [LEFT_W-1:0] left_q;
    logic              go, more;

    assign go   = lau_i && !load_n_i;
    assign more = left_q > LEFT_W'(1);

    always_comb begin
        unique case (state_q)
            TX_IDLE: state_d = (go && armed_q) ? TX_SEND : TX_IDLE;
            TX_SEND: state_d = (go && !more && !armed_q) ? TX_IDLE : TX_SEND;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= TX_IDLE;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            out_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            armed_q  <= 1'b0;
            left_q   <= '0;
        end else begin
            if (rd_i) begin
                pend_q   <= {{PAD_W{1'b0}}, rd_data_i};
                pend_v_q <= 1'b1;
                armed_q  <= 1'b0;
            end else if (smp_i && !load_n_i && pend_v_q) begin
                armed_q  <= 1'b1;
            end
            if (go) begin
                if (state_q == TX_SEND && more) begin
                    out_q  <= {out_q[WORD_W-2:0], 1'b0};
                    left_q <= left_q - 1'b1;
                end else if (armed_q) begin
                    out_q    <= pend_q;
                    left_q   <= LEFT_W'(WORD_W);
                    pend_v_q <= 1'b0;
                    armed_q  <= 1'b0;
                end else begin
                    out_q  <= '0;
                    left_q <= '0;
                end
            end
        end
    end

    always_comb sdo_o = out_q[WORD_W-1];

    AST_SDO_HOLD_STROBE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_n_i |=> $stable(sdo_o)); // R6
    AST_SDO_LAUNCH_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !lau_i |=> $stable(sdo_o)); // R10
    AST_IDLE_SDO_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == TX_IDLE) |-> !sdo_o); // R10
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              load_n_i,
    input  logic              pol_i,
    output logic              sdo_o,
    output logic [FLAT_W-1:0] regs_o
);
    logic              sclk_q, rise, fall, smp, lau;
    logic              wr, rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sclk_q <= 1'b0;
        else          sclk_q <= sclk_i;
    end

    assign rise = sclk_i && !sclk_q;
    assign fall = !sclk_i && sclk_q;
    assign smp  = pol_i ? rise : fall;
    assign lau  = pol_i ? fall : rise;

    srp_rx u_rx (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .smp_i(smp), .load_n_i(load_n_i), .sdi_i(sdi_i),
        .wr_o(wr), .rd_o(rd), .addr_o(addr), .data_o(wdata)
    );

    srp_regfile u_regs (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_i(wr), .addr_i(addr), .data_i(wdata),
        .rd_data_o(rdata), .regs_o(regs_o)
    );

    srp_tx u_tx (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .smp_i(smp), .lau_i(lau), .load_n_i(load_n_i),
        .rd_i(rd), .rd_data_i(rdata), .sdo_o(sdo_o)
    );

    AST_ONE_EDGE_KIND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(smp && lau)); // R3
endmodule

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
    import srp_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sclk, sdi, load_n, pol;
    logic sdo;
    logic [FLAT_W-1:0] regs;
    int n_run = 0, n_fail = 0;
    logic [9:0] model [11];

    serial_reg_port u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .sclk_i(sclk), .sdi_i(sdi), .load_n_i(load_n),
        .pol_i(pol), .sdo_o(sdo), .regs_o(regs)
    );

    function automatic logic [9:0] bm_mask(input int a);
        case (a)
            0: return 10'h380;  1: return 10'h3FF;  2: return 10'h1FF;  3: return 10'h1FF;
            6: return 10'h0FF;  7: return 10'h3FF;  8: return 10'h01F;  9: return 10'h01F;
            10: return 10'h0FF;
            default: return 10'h000;
        endcase
    endfunction

    function automatic logic [9:0] bm_def(input int a);
        case (a)
            0: return 10'h380;  6: return 10'd64;  9: return 10'h010;
            default: return 10'h000;
        endcase
    endfunction

    function automatic void mdl_reset();
        for (int i = 0; i < 11; i++) model[i] = bm_def(i);
    endfunction

    function automatic void mdl_write(input logic [4:0] a, input logic [9:0] d);
        if (a == 5'd0 && d[0]) mdl_reset();
        else if (a < 5'd11) model[a] = d & bm_mask(int'(a));
    endfunction

    function automatic logic [15:0] mdl_reply(input logic [4:0] a);
        return (a < 5'd11) ? {6'b0, model[a]} : 16'h0000;
    endfunction

    function automatic logic [127:0] mdl_flat();
        logic [127:0] f = '0;
        for (int i = 0; i < 11; i++) f[i*10 +: 10] = model[i];
        return f;
    endfunction

    function automatic logic [15:0] mkw(input logic rw, input logic [4:0] a, input logic [9:0] d);
        return {rw, a, d};
    endfunction

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(req, "register bus", {18'b0, regs}, mdl_flat());
    endtask

    task automatic frame_begin();
        sclk = ~pol;
        repeat (4) @(negedge clk);
        load_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (4) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic clock_bits(input logic [63:0] bits, input int n, output logic [63:0] got);
        got = '0;
        for (int k = 0; k < n; k++) begin
            sdi = bits[n-1-k];
            repeat (4) @(negedge clk);
            got[n-1-k] = sdo;
            sclk = pol;
            repeat (4) @(negedge clk);
            sclk = ~pol;
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [9:0] d);
        logic [63:0] g;
        frame_begin();
        clock_bits({48'b0, mkw(1'b0, a, d)}, 16, g);
        frame_end();
        mdl_write(a, d);
    endtask

    task automatic do_read(input logic [4:0] a, output logic [15:0] rep);
        logic [63:0] g;
        frame_begin();
        clock_bits({31'b0, mkw(1'b1, a, 10'h000), mkw(1'b0, 5'd31, 10'h2AA), 1'b1}, 33, g);
        frame_end();
        rep = g[15:0];
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished within 150000 cycles");
        summary();
        $finish;
    end

    initial begin : main
        logic [15:0] rep, rep2;
        logic [63:0] g;
        logic [9:0]  d;
        logic [4:0]  a;
        void'($urandom(32'd7));
        rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; load_n = 1'b1; pol = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
        repeat (2) @(negedge clk);
        check("R9", "defaults after reset", {18'b0, regs}, mdl_flat());
        check("R10", "sdo idle after reset", {127'b0, sdo}, 128'd0);

        do_read(5'd0, rep);
        check("R5", "control default readback", {112'b0, rep}, {112'b0, mdl_reply(5'd0)});
        do_read(5'd6, rep);
        check("R9", "target level default readback", {112'b0, rep}, {112'b0, 16'd64});

        // R1 R4: every implemented address, rising-edge sampling
        for (int i = 1; i < 11; i++) begin
            d = 10'($urandom);
            do_write(5'(i), d);
            check_regs("R1");
            do_read(5'(i), rep);
            check("R4", "masked readback", {112'b0, rep}, {112'b0, mdl_reply(5'(i))});
        end

        // R3: falling-edge sampling
        pol = 1'b0;
        do_write(5'd7, 10'h2B5);
        check_regs("R3");
        do_read(5'd7, rep);
        check("R3", "readback with falling sampling", {112'b0, rep}, {112'b0, mdl_reply(5'd7)});
        pol = 1'b1;

        // R2: two words in one strobe period
        frame_begin();
        clock_bits({32'b0, mkw(1'b0, 5'd2, 10'h0F3), mkw(1'b0, 5'd3, 10'h1C4)}, 32, g);
        frame_end();
        mdl_write(5'd2, 10'h0F3);
        mdl_write(5'd3, 10'h1C4);
        check_regs("R2");

        // R2: partial word dropped
        frame_begin();
        clock_bits({48'b0, mkw(1'b0, 5'd1, 10'h3FF)} >> 6, 10, g);
        frame_end();
        check_regs("R2");

        // R7: reserved and unused addresses
        do_write(5'd4, 10'h3FF);
        do_write(5'd5, 10'h3FF);
        do_write(5'd20, 10'h3FF);
        check_regs("R7");
        do_read(5'd4, rep);
        check("R7", "reserved read", {112'b0, rep}, 128'd0);
        do_read(5'd20, rep);
        check("R7", "unused read", {112'b0, rep}, 128'd0);

        // R11: writes while standby bit cleared
        do_write(5'd0, 10'h000);
        do_write(5'd1, 10'h155);
        check_regs("R11");

        // R8: self reset through address 0 bit 0
        do_write(5'd0, 10'h001);
        check("R8", "self reset", {18'b0, regs}, mdl_flat());
        do_read(5'd0, rep);
        check("R8", "self reset bit not stored", {112'b0, rep}, {112'b0, 16'h0380});

        // R8: hardware reset
        do_write(5'd10, 10'h0AB);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
        repeat (2) @(negedge clk);
        check("R8", "hardware reset", {18'b0, regs}, mdl_flat());

        // R6: reply held across strobe release
        do_write(5'd1, 10'h2C7);
        frame_begin();
        clock_bits({48'b0, mkw(1'b1, 5'd1, 10'h000)}, 16, g);
        frame_end();
        for (int k = 0; k < 3; k++) begin
            sclk = pol; repeat (4) @(negedge clk);
            sclk = ~pol; repeat (4) @(negedge clk);
        end
        check("R6", "sdo while strobe high", {127'b0, sdo}, 128'd0);
        frame_begin();
        clock_bits({47'b0, mkw(1'b0, 5'd31, 10'h000), 1'b0}, 17, g);
        frame_end();
        check("R6", "delayed reply", {112'b0, g[15:0]}, {112'b0, mdl_reply(5'd1)});

        // R5: back-to-back requests
        pol = 1'b0;
        frame_begin();
        clock_bits({15'b0, mkw(1'b1, 5'd1, 10'h000), mkw(1'b1, 5'd6, 10'h3FF),
                    mkw(1'b0, 5'd31, 10'h000), 1'b0}, 49, g);
        frame_end();
        check("R5", "first chained reply", {112'b0, g[31:16]}, {112'b0, mdl_reply(5'd1)});
        check("R5", "second chained reply", {112'b0, g[15:0]}, {112'b0, mdl_reply(5'd6)});
        check("R10", "sdo after replies", {127'b0, sdo}, 128'd0);

        // random mix
        for (int it = 0; it < 30; it++) begin
            pol = 1'($urandom);
            a = 5'($urandom % 16);
            d = 10'($urandom);
            if (a == 5'd0) d[0] = (($urandom % 8) == 0);
            if ($urandom % 2) begin
                do_write(a, d);
                check_regs("R1");
            end else begin
                rep2 = mdl_reply(a);
                do_read(a, rep);
                check("R5", "random readback", {112'b0, rep}, {112'b0, rep2});
            end
        end

        summary();
        $finish;
    end
endmodule